// File: doc/BRIEF.md
# Exception Entry Frame Stacker

When an interrupt or exception is taken, the processor must save eight registers to the active stack before the handler starts. This sequencer does that work. A one-cycle start strobe provides the current stack pointer and the eight register values. The block captures them and writes an eight-word frame into memory. It uses a single-word write port with a valid/ready handshake, and it moves through the frame from the highest address down to the lowest. After the last word is accepted, it reports the lowered stack pointer and gives a one-cycle completion pulse.

The stack is full-descending, so the frame occupies the 32 bytes directly below the incoming stack pointer. The new stack pointer addresses the saved R0 word. The saved status word sits just beneath the old stack pointer. Frame restore on exception return, vector fetch and extended or floating-point state are handled elsewhere.

Top module: `exframe_pusher`

## Requirements
- R1: While reset is asserted and after its release with no start, wr_valid_o is 0, done_o is 0 and sp_new_o is 0.
- R2: The first write of a push carries the status word (psr_i), at address sp_i - 0x04, where sp_i is the value sampled with the start strobe.
- R3: Word slot s (R0=0, R1=1, R2=2, R3=3, R12=4, LR=5, PC=6, PSR=7) is written at address (sp_i - 0x20) + 4*s. Slots are written in descending order 7 down to 0, one per accepted handshake (wr_valid_o and wr_ready_i both 1 at a rising edge). Each accepted address is 4 below the previous one.
- R4: Every push produces exactly eight accepted writes. wr_valid_o stays 0 while no push is in progress, whatever wr_ready_i does.
- R5: While wr_valid_o is 1 and wr_ready_i is 0, wr_valid_o, wr_addr_o and wr_data_o hold their values into the next cycle.
- R6: done_o is 1 for exactly the one cycle after the eighth write is accepted. From that cycle on, sp_new_o equals sp_i - 0x20 until the next push completes.
- R7: Register and stack pointer inputs are captured on the accepted start strobe. Changes on them during the push do not affect addresses, data or sp_new_o.
- R8: A start strobe that arrives while a push is in progress is ignored. The current frame continues unchanged and no extra writes follow.
- R9: Address and stack pointer arithmetic wrap modulo 2^AW, so a stack pointer below 0x20 yields a frame at the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin stacking a frame (one-cycle strobe) |
| sp_i | input | AW | Stack pointer before entry |
| r0_i | input | DW | Value of R0 |
| r1_i | input | DW | Value of R1 |
| r2_i | input | DW | Value of R2 |
| r3_i | input | DW | Value of R3 |
| r12_i | input | DW | Value of R12 |
| lr_i | input | DW | Value of the link register |
| pc_i | input | DW | Return program counter |
| psr_i | input | DW | Status word |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | DW | Write data word |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory accepts the write |
| done_o | output | 1 | One-cycle completion pulse |
| sp_new_o | output | AW | Stack pointer after stacking |

## Verification
The assertions check the cycle-level rules on every cycle. These are handshake stability under back-pressure, the 4-byte downward step between accepted addresses, the single-cycle completion pulse that follows only the final acceptance, the status word at sp-4 as the first request, and the stability of the holding register between starts. The other properties need a whole push to show them: the full slot-to-offset mapping, exactly eight writes, wrap-around near address zero, immunity to input changes and to stray start strobes, and the final stack pointer value. Only the bench's sweeps over stack pointers, ready patterns and disturbances can show those.

// File: rtl/exf_pkg.sv
package exf_pkg;
  localparam int FRAME_WORDS = 8;
  localparam int IDX_W       = $clog2(FRAME_WORDS);
  localparam int WORD_BYTES  = 4;
  localparam int WB_LOG2     = $clog2(WORD_BYTES);
  localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;

  typedef logic [IDX_W-1:0] slot_t;

  // Slot number equals word offset from the final stack pointer.
  typedef enum logic [IDX_W-1:0] {
    SLOT_R0  = 3'd0,
    SLOT_R1  = 3'd1,
    SLOT_R2  = 3'd2,
    SLOT_R3  = 3'd3,
    SLOT_R12 = 3'd4,
    SLOT_LR  = 3'd5,
    SLOT_PC  = 3'd6,
    SLOT_PSR = 3'd7
  } slot_e;
endpackage

// File: rtl/exf_hold.sv
module exf_hold
  import exf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cap_en,
  input  logic [FRAME_WORDS-1:0][DW-1:0]  regs_i,
  output logic [FRAME_WORDS-1:0][DW-1:0]  regs_q
);
  logic [FRAME_WORDS-1:0][DW-1:0] regs_d;

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slot
    always_comb begin
      regs_d[g] = regs_q[g];
      if (cap_en) regs_d[g] = regs_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= regs_d[g];
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(regs_q)); // R7
endmodule

// File: rtl/exf_ctrl.sv
module exf_ctrl
  import exf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] sp_i,
  input  logic          ready_i,
  output logic          busy_o,
  output slot_t         idx_o,
  output logic [AW-1:0] base_o,
  output logic          cap_en_o,
  output logic          done_o,
  output logic [AW-1:0] sp_new_o
);
  localparam logic [AW-1:0] FRAME_SZ = AW'(FRAME_BYTES);
  localparam slot_t         TOP_IDX  = slot_t'(FRAME_WORDS - 1);

  logic          busy_q, busy_d;
  slot_t         idx_q, idx_d;
  logic [AW-1:0] base_q, base_d;
  logic          done_q, done_d;
  logic [AW-1:0] spn_q, spn_d;
  logic          accept, last;

  assign accept = busy_q & ready_i;
  assign last   = (idx_q == '0);

  always_comb begin
    busy_d   = busy_q;
    idx_d    = idx_q;
    base_d   = base_q;
    spn_d    = spn_q;
    done_d   = 1'b0;
    cap_en_o = 1'b0;
    if (!busy_q && start_i) begin
      busy_d   = 1'b1;
      idx_d    = TOP_IDX;
      base_d   = sp_i - FRAME_SZ;
      cap_en_o = 1'b1;
    end else if (accept) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        spn_d  = base_q;
      end else begin
        idx_d = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      done_q <= 1'b0;
      spn_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      base_q <= base_d;
      done_q <= done_d;
      spn_q  <= spn_d;
    end
  end

  assign busy_o   = busy_q;
  assign idx_o    = idx_q;
  assign base_o   = base_q;
  assign done_o   = done_q;
  assign sp_new_o = spn_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(accept && last)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !accept) |=> ($stable(idx_q) && $stable(base_q))); // R8
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && accept && !last) |=> (busy_q && idx_q == $past(idx_q) - 1'b1)); // R4
endmodule

// File: rtl/exf_wmux.sv
module exf_wmux
  import exf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [AW-1:0]                  base_i,
  input  slot_t                          idx_i,
  input  logic [FRAME_WORDS-1:0][DW-1:0] regs_i,
  output logic [AW-1:0]                  addr_o,
  output logic [DW-1:0]                  data_o
);
  always_comb begin
    addr_o = base_i + (AW'(idx_i) << WB_LOG2);
    data_o = regs_i[idx_i];
  end
endmodule

// File: rtl/exframe_pusher.sv
module exframe_pusher
  import exf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] r0_i,
  input  logic [DW-1:0] r1_i,
  input  logic [DW-1:0] r2_i,
  input  logic [DW-1:0] r3_i,
  input  logic [DW-1:0] r12_i,
  input  logic [DW-1:0] lr_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] psr_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic          done_o,
  output logic [AW-1:0] sp_new_o
);
  logic [FRAME_WORDS-1:0][DW-1:0] regs_in, regs_q;
  logic                           busy, cap_en;
  slot_t                          idx;
  logic [AW-1:0]                  base;

  always_comb begin
    regs_in           = '0;
    regs_in[SLOT_R0]  = r0_i;
    regs_in[SLOT_R1]  = r1_i;
    regs_in[SLOT_R2]  = r2_i;
    regs_in[SLOT_R3]  = r3_i;
    regs_in[SLOT_R12] = r12_i;
    regs_in[SLOT_LR]  = lr_i;
    regs_in[SLOT_PC]  = pc_i;
    regs_in[SLOT_PSR] = psr_i;
  end

  exf_ctrl #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sp_i     (sp_i),
    .ready_i  (wr_ready_i),
    .busy_o   (busy),
    .idx_o    (idx),
    .base_o   (base),
    .cap_en_o (cap_en),
    .done_o   (done_o),
    .sp_new_o (sp_new_o)
  );

  exf_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .regs_i (regs_in),
    .regs_q (regs_q)
  );

  exf_wmux #(.AW(AW), .DW(DW)) u_wmux (
    .base_i (base),
    .idx_i  (idx),
    .regs_i (regs_q),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o)
  );

  assign wr_valid_o = busy;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && !done_o && wr_addr_o != base) |=>
      (wr_valid_o && wr_addr_o == $past(wr_addr_o) - AW'(WORD_BYTES))); // R3
  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !wr_valid_o) |=>
      (wr_valid_o && wr_addr_o == $past(sp_i) - AW'(WORD_BYTES) &&
       wr_data_o == $past(psr_i))); // R2
  AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_valid_o); // R4
endmodule

// File: tb/sim_exframe_pusher.sv
`timescale 1ns/1ps
module sim_exframe_pusher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] sp_i;
  logic [31:0] r0_i, r1_i, r2_i, r3_i, r12_i, lr_i, pc_i, psr_i;
  logic [31:0] wr_addr_o, wr_data_o, sp_new_o;
  logic        wr_valid_o, wr_ready_i, done_o;

  int nchk = 0;
  int nbad = 0;
  logic [31:0] vals [8];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  exframe_pusher u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sp_i(sp_i),
    .r0_i(r0_i), .r1_i(r1_i), .r2_i(r2_i), .r3_i(r3_i), .r12_i(r12_i),
    .lr_i(lr_i), .pc_i(pc_i), .psr_i(psr_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_valid_o(wr_valid_o),
    .wr_ready_i(wr_ready_i), .done_o(done_o), .sp_new_o(sp_new_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive_regs(input logic [31:0] seed);
    for (int s = 0; s < 8; s++) vals[s] = (seed * 32'h9E3779B9) ^ (32'(s) << 24) ^ 32'(s * 17);
    r0_i = vals[0]; r1_i = vals[1]; r2_i = vals[2]; r3_i = vals[3];
    r12_i = vals[4]; lr_i = vals[5]; pc_i = vals[6]; psr_i = vals[7];
  endtask

  function automatic logic ready_pat(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return cyc[0];
      2: return (cyc % 3) == 2;
      default: return lfsr[0];
    endcase
  endfunction

  // One full push; disturb: scramble inputs and issue stray starts during the push.
  task automatic push(input logic [31:0] sp, input logic [31:0] seed, input int mode, input bit disturb);
    logic [31:0] exp_base;
    int n = 0;
    int cyc = 0;
    exp_base = sp - 32'h20;
    @(negedge clk);
    drive_regs(seed);
    sp_i = sp;
    start_i = 1'b1;
    wr_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    while (n < 8 && cyc < 200) begin
      if (disturb) begin
        r0_i = ~r0_i; psr_i = psr_i + 32'h11; pc_i = ~pc_i; sp_i = sp_i ^ 32'h0F00_0000;
        start_i = (cyc % 4) == 1; // R8 stray start
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_ready_i = ready_pat(mode, cyc);
      #1;
      if (wr_valid_o && wr_ready_i) begin
        check($sformatf("R3 addr word %0d", n), wr_addr_o, exp_base + 32'(4 * (7 - n)));
        check($sformatf("R7 data word %0d", n), wr_data_o, vals[7 - n]);
        if (n == 0) check("R2 first addr", wr_addr_o, sp - 32'h4);
        n++;
      end
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    wr_ready_i = 1'b1;
    check("R4 eight writes", 32'(n), 32'd8);
    check("R6 done pulse", {31'b0, done_o}, 32'd1);
    check("R6 sp_new", sp_new_o, exp_base);
    check("R4 idle after", {31'b0, wr_valid_o}, 32'd0);
    @(negedge clk);
    check("R6 done one cycle", {31'b0, done_o}, 32'd0);
    check("R4 no write when idle", {31'b0, wr_valid_o}, 32'd0);
    check("R6 sp_new held", sp_new_o, exp_base);
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] sps [6];
    sps[0] = 32'h2000_1000; sps[1] = 32'h0000_0010; sps[2] = 32'h0000_0000;
    sps[3] = 32'hFFFF_FFF8; sps[4] = 32'h0000_0020; sps[5] = 32'h8000_0004;
    rst_n = 1'b0; start_i = 1'b0; sp_i = '0; wr_ready_i = 1'b1;
    drive_regs(32'd1);
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'b0, wr_valid_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid", {31'b0, wr_valid_o}, 32'd0);
    check("R1 done", {31'b0, done_o}, 32'd0);
    check("R1 sp_new", sp_new_o, 32'd0);
    for (int i = 0; i < 6; i++)
      for (int m = 0; m < 4; m++)
        for (int d = 0; d < 2; d++) begin
          // R9 wrap exercised by sp values below 0x20
          push(sps[i], 32'(i * 8 + m * 2 + d + 3), m, d[0]);
        end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule